// File: doc/BRIEF.md
# Pipelined ADC Digital Error Correction

This block is the digital back end of a 10-bit pipelined converter built from seven 1.5-bit stages and a 3-bit flash stage at the tail. Two analog stages settle per clock, so one sample's decisions reach the block spread over four consecutive cycles. Stages 1 and 2 come in the cycle the sample is taken. Stages 3 and 4 come one cycle later, stages 5 and 6 two cycles later, and stage 7 with the flash code three cycles later. The block delays each stage's decision by the right number of cycles, so that all eight decisions of one sample sit side by side.

It then adds the aligned signed digits with binary weights that overlap by one bit per stage. A decision that was one step wrong in an early stage is made good by the residue that the later stages see, and the output does not change. The sum is clamped to the 10-bit range, and the word leaves with a valid flag, an out-of-range flag and an illegal-code flag. Reset is asynchronous and active low, and the block releases it internally through a synchronizer.

Top module: `pipe_adc_corrector`

## Requirements
- R1: Each 1.5-bit stage decision is a 2-bit code at bits [2(i-1)+1 : 2(i-1)] of `stg_code_i` for stage i: 00 means -1, 01 means 0 and 10 means +1. Code 11 counts as digit 0, and `code_err_o` is high in the output cycle of that same sample, and only in that cycle.
- R2: The result is 512 + sum over i = 1..7 of digit_i * 2^(10-i) + flash value, where the flash value is the unsigned 3-bit `flash_i`. All-zero digits with flash 0 give 512.
- R3: For one sample, stages 1 and 2 are presented in cycle n, stages 3 and 4 in cycle n+1, stages 5 and 6 in cycle n+2, and stage 7 with `flash_i` in cycle n+3. Samples follow each other every cycle without mixing.
- R4: A sample's result appears on the outputs right after the sixth rising edge, counting the edge that captures its stage-1 code as the first.
- R5: A sum below 0 gives `res_o` = 0 with `range_o` high. A sum of exactly 0 gives 0 with `range_o` low.
- R6: A sum above 1023 gives `res_o` = 1023 with `range_o` high. A sum of exactly 1023 gives 1023 with `range_o` low.
- R7: Digit patterns with equal weighted sums give identical outputs, so a digit one step off in an early stage, offset by the residue in later stages, leaves the result unchanged.
- R8: `res_vld_o` is low after reset and rises after the eighth rising edge that follows the release of `rst_n`: two edges to release the internal reset and six to fill the pipeline. It then stays high until the next reset.
- R9: While `rst_n` is low, all outputs are 0, and asserting it takes effect without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stg_code_i | input | 14 | Decision codes of the seven 1.5-bit stages, stage i at bits 2(i-1)+1:2(i-1) |
| flash_i | input | 3 | Unsigned code of the final flash stage |
| res_o | output | 10 | Corrected and clamped result |
| res_vld_o | output | 1 | Result valid once the pipeline has filled |
| range_o | output | 1 | Sum was clamped at either end |
| code_err_o | output | 1 | An illegal stage code took part in this result |

## Verification
Each sample's stage codes are driven with the skew of R3, so stage pairs go in on successive cycles. The sample's result is read at the falling edge that follows the sixth rising edge after its stage-1 code was captured. Several samples are in flight at any time, so a wrong delay in any lane makes neighbouring vectors mix. A single-sample impulse on an idle stream is checked one cycle before, at, and one cycle after its due cycle to pin down R4. The valid flag is read after the seventh and the eighth edge after reset release. The checker ties an illegal code in stage 1 to the error flag six edges later, and an illegal code in stage 7 to the flag three edges later.

// File: rtl/pac_pkg.sv
package pac_pkg;

  // signed digit of a 1.5-bit stage
  typedef logic signed [1:0] sdig_t;

  typedef struct packed {
    logic  bad;
    sdig_t dig;
  } sdec_t;

  localparam int DEC_W = 3;

  // 00 -> -1, 01 -> 0, 10 -> +1, 11 -> 0 with error mark
  function automatic sdec_t decode_code(input logic [1:0] code);
    sdec_t r;
    r.bad = 1'b0;
    r.dig = 2'sd0;
    case (code)
      2'b00:   r.dig = -2'sd1;
      2'b10:   r.dig = 2'sd1;
      2'b11:   r.bad = 1'b1;
      default: r.dig = 2'sd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pac_rst_sync.sv
module pac_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/pac_delay.sv
module pac_delay #(
  parameter int W     = 3,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] line_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) line_q[k] <= '0;
    end else begin
      line_q[0] <= d_i;
      for (int k = 1; k < DEPTH; k++) line_q[k] <= line_q[k-1];
    end
  end

  assign q_o = line_q[DEPTH-1];

endmodule

// File: rtl/pac_align.sv
module pac_align
  import pac_pkg::*;
#(
  parameter int NSTG       = 7,
  parameter int PER_CYC    = 2,
  parameter int FLASH_BITS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  sdec_t [NSTG-1:0]      dec_i,
  input  logic [FLASH_BITS-1:0] flash_i,
  output sdec_t [NSTG-1:0]      dec_o,
  output logic [FLASH_BITS-1:0] flash_o
);

  localparam int LAST = NSTG / PER_CYC;
  localparam int FDLY = LAST - (NSTG / PER_CYC);

  sdec_t [NSTG-1:0]      skew_w;
  logic [FLASH_BITS-1:0] fskew_w;
  sdec_t [NSTG-1:0]      dec_q;
  logic [FLASH_BITS-1:0] flash_q;

  // early stages wait for the late ones of the same sample
  for (genvar i = 0; i < NSTG; i++) begin : g_lane
    localparam int DLY = LAST - (i / PER_CYC);
    if (DLY > 0) begin : g_dly
      pac_delay #(.W(DEC_W), .DEPTH(DLY)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (dec_i[i]),
        .q_o   (skew_w[i])
      );
    end else begin : g_thru
      assign skew_w[i] = dec_i[i];
    end
  end

  if (FDLY > 0) begin : g_fdly
    pac_delay #(.W(FLASH_BITS), .DEPTH(FDLY)) u_fdly (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (flash_i),
      .q_o   (fskew_w)
    );
  end else begin : g_fthru
    assign fskew_w = flash_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q   <= '0;
      flash_q <= '0;
    end else begin
      dec_q   <= skew_w;
      flash_q <= fskew_w;
    end
  end

  assign dec_o   = dec_q;
  assign flash_o = flash_q;

endmodule

// File: rtl/pac_combine.sv
module pac_combine
  import pac_pkg::*;
#(
  parameter int NSTG       = 7,
  parameter int RES_BITS   = 10,
  parameter int FLASH_BITS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  sdec_t [NSTG-1:0]      dec_i,
  input  logic [FLASH_BITS-1:0] flash_i,
  output logic [RES_BITS-1:0]   res_o,
  output logic                  rng_o,
  output logic                  bad_o
);

  localparam int SUM_W = RES_BITS + 2;
  localparam int MID   = 1 << (RES_BITS - 1);
  localparam int TOPV  = (1 << RES_BITS) - 1;

  logic signed [SUM_W-1:0] acc_d, acc_q;
  logic                    bad1_d, bad1_q;
  logic [RES_BITS-1:0]     res_d, res_q;
  logic                    rng_d, rng_q, bad2_q;

  // weighted signed-digit sum, one bit of overlap per stage
  always_comb begin
    acc_d  = SUM_W'(MID);
    bad1_d = 1'b0;
    for (int i = 0; i < NSTG; i++) begin
      acc_d  = acc_d + (SUM_W'(dec_i[i].dig) <<< (RES_BITS - 1 - i));
      bad1_d = bad1_d | dec_i[i].bad;
    end
    acc_d = acc_d + SUM_W'($signed({1'b0, flash_i}));
  end

  // saturate at both ends
  always_comb begin
    if (acc_q < 0) begin
      res_d = '0;
      rng_d = 1'b1;
    end else if (acc_q > SUM_W'(TOPV)) begin
      res_d = RES_BITS'(TOPV);
      rng_d = 1'b1;
    end else begin
      res_d = acc_q[RES_BITS-1:0];
      rng_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      bad1_q <= 1'b0;
      res_q  <= '0;
      rng_q  <= 1'b0;
      bad2_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      bad1_q <= bad1_d;
      res_q  <= res_d;
      rng_q  <= rng_d;
      bad2_q <= bad1_q;
    end
  end

  assign res_o = res_q;
  assign rng_o = rng_q;
  assign bad_o = bad2_q;

endmodule

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector
  import pac_pkg::*;
#(
  parameter int NSTG        = 7,
  parameter int PER_CYC     = 2,
  parameter int RES_BITS    = 10,
  parameter int FLASH_BITS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*NSTG-1:0]     stg_code_i,
  input  logic [FLASH_BITS-1:0] flash_i,
  output logic [RES_BITS-1:0]   res_o,
  output logic                  res_vld_o,
  output logic                  range_o,
  output logic                  code_err_o
);

  localparam int LAST = NSTG / PER_CYC;
  localparam int LAT  = LAST + 3;
  localparam int FW   = $clog2(LAT + 1);

  logic                  rst_int_n;
  sdec_t [NSTG-1:0]      dec_w;
  sdec_t [NSTG-1:0]      al_dec_w;
  logic [FLASH_BITS-1:0] al_flash_w;
  logic [RES_BITS-1:0]   res_w;
  logic                  rng_w, bad_w;
  logic [FW-1:0]         fill_d, fill_q;
  logic                  full_w;

  pac_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  for (genvar i = 0; i < NSTG; i++) begin : g_dec
    assign dec_w[i] = decode_code(stg_code_i[2*i +: 2]);
  end

  pac_align #(.NSTG(NSTG), .PER_CYC(PER_CYC), .FLASH_BITS(FLASH_BITS)) u_align (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .dec_i   (dec_w),
    .flash_i (flash_i),
    .dec_o   (al_dec_w),
    .flash_o (al_flash_w)
  );

  pac_combine #(.NSTG(NSTG), .RES_BITS(RES_BITS), .FLASH_BITS(FLASH_BITS)) u_comb (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .dec_i   (al_dec_w),
    .flash_i (al_flash_w),
    .res_o   (res_w),
    .rng_o   (rng_w),
    .bad_o   (bad_w)
  );

  // fill tracking: count edges until the first real sample is out
  assign full_w = (fill_q == FW'(LAT));

  always_comb begin
    fill_d = full_w ? fill_q : fill_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) fill_q <= '0;
    else            fill_q <= fill_d;
  end

  assign res_o      = res_w;
  assign res_vld_o  = full_w;
  assign range_o    = rng_w & full_w;
  assign code_err_o = bad_w & full_w;

endmodule

// File: rtl/pac_checker.sv
module pac_checker #(
  parameter int RES_BITS   = 10,
  parameter int LAT        = 6,
  parameter int FILL_EDGES = 8,
  parameter int LAST_LAG   = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          code_first_i,
  input logic [1:0]          code_last_i,
  input logic [RES_BITS-1:0] res_o,
  input logic                res_vld_o,
  input logic                range_o,
  input logic                code_err_o
);

  localparam logic [RES_BITS-1:0] TOPV = '1;

  logic [4:0] rcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rcnt_q <= '0;
    else if (rcnt_q != '1)  rcnt_q <= rcnt_q + 1'b1;
  end

  // R8: valid rises exactly after the fill window
  p_fill_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o == (rcnt_q >= 5'(FILL_EDGES)));

  // R8: valid never drops without reset
  p_valid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |=> res_vld_o);

  // R6: clamping only ever lands on an end of the range
  p_clamp_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    range_o |-> (res_o == '0 || res_o == TOPV));

  // R5: an interior result is never flagged
  p_interior_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && res_o != '0 && res_o != TOPV) |-> !range_o);

  // R1: illegal code in the first stage reaches the flag after full latency
  p_bad_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && $past(code_first_i == 2'b11, LAT)) |-> code_err_o);

  // R1: illegal code in the last stage reaches the flag after its shorter lag
  p_bad_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && $past(code_last_i == 2'b11, LAST_LAG)) |-> code_err_o);

endmodule

bind pipe_adc_corrector pac_checker #(
  .RES_BITS   (RES_BITS),
  .LAT        (LAT),
  .FILL_EDGES (SYNC_STAGES + LAT),
  .LAST_LAG   (LAT - LAST)
) u_pac_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .code_first_i (stg_code_i[1:0]),
  .code_last_i  (stg_code_i[2*NSTG-1 -: 2]),
  .res_o        (res_o),
  .res_vld_o    (res_vld_o),
  .range_o      (range_o),
  .code_err_o   (code_err_o)
);

// File: tb/pipe_adc_corrector_bench.sv
module pipe_adc_corrector_bench;

  localparam int NV = 14;
  // {c1..c7 (2b each, c1 first), flash(3), expected res(10), range(1), err(1)}
  // codes: 00=-1 01=0 10=+1 11=illegal
  localparam logic [28:0] TBL [NV] = '{
    {2'b01,2'b01,2'b01,2'b01,2'b01,2'b01,2'b01, 3'd0, 10'd512,  1'b0,1'b0}, // R2 mid
    {2'b01,2'b01,2'b01,2'b01,2'b01,2'b01,2'b01, 3'd5, 10'd517,  1'b0,1'b0}, // R2 flash
    {2'b01,2'b10,2'b01,2'b01,2'b01,2'b01,2'b01, 3'd0, 10'd768,  1'b0,1'b0}, // R2 stage2
    {2'b10,2'b00,2'b01,2'b01,2'b01,2'b01,2'b01, 3'd0, 10'd768,  1'b0,1'b0}, // R7
    {2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00, 3'd0, 10'd0,    1'b1,1'b0}, // R5 under
    {2'b10,2'b10,2'b10,2'b10,2'b10,2'b10,2'b10, 3'd7, 10'd1023, 1'b1,1'b0}, // R6 over
    {2'b00,2'b01,2'b01,2'b01,2'b01,2'b01,2'b01, 3'd0, 10'd0,    1'b0,1'b0}, // R5 exact 0
    {2'b01,2'b10,2'b10,2'b10,2'b10,2'b10,2'b10, 3'd7, 10'd1023, 1'b0,1'b0}, // R6 exact max
    {2'b10,2'b01,2'b01,2'b01,2'b01,2'b01,2'b01, 3'd0, 10'd1023, 1'b1,1'b0}, // R6 one over
    {2'b01,2'b01,2'b11,2'b01,2'b01,2'b01,2'b01, 3'd2, 10'd514,  1'b0,1'b1}, // R1 illegal
    {2'b00,2'b10,2'b01,2'b01,2'b01,2'b01,2'b01, 3'd3, 10'd259,  1'b0,1'b0}, // R7
    {2'b01,2'b00,2'b01,2'b01,2'b01,2'b01,2'b01, 3'd3, 10'd259,  1'b0,1'b0}, // R7
    {2'b10,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00, 3'd7, 10'd527,  1'b0,1'b0}, // R7 residue
    {2'b01,2'b01,2'b01,2'b01,2'b01,2'b01,2'b10, 3'd7, 10'd527,  1'b0,1'b0}  // R7 residue
  };
  localparam logic [16:0] IDLE = {{7{2'b01}}, 3'd0};

  logic        clk;
  logic        rst_n;
  logic [13:0] stg_code;
  logic [2:0]  flash;
  logic [9:0]  res;
  logic        vld, rng, err;
  int          n_cmp;
  int          n_bad;

  pipe_adc_corrector u_pipe_adc_corrector (
    .clk        (clk),
    .rst_n      (rst_n),
    .stg_code_i (stg_code),
    .flash_i    (flash),
    .res_o      (res),
    .res_vld_o  (vld),
    .range_o    (rng),
    .code_err_o (err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic string vtag(input int i);
    case (i)
      0, 1, 2:           return "R2/R3";
      4, 6:              return "R5";
      5, 7, 8:           return "R6";
      9:                 return "R1";
      default:           return "R7";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mode 0: table stream; mode 1: single impulse of table entry 2 at index 0
  function automatic logic [16:0] fetch(input int idx, input int mode);
    if (mode == 0) return (idx >= 0 && idx < NV) ? TBL[idx][28:12] : IDLE;
    return (idx == 0) ? TBL[2][28:12] : IDLE;
  endfunction

  // R3: stage pair k/2 of a sample goes in k/2 cycles after its first pair
  task automatic drive_step(input int t, input int mode);
    logic [13:0] cv;
    logic [16:0] f;
    for (int k = 0; k < 7; k++) begin
      f = fetch(t - k / 2, mode);
      cv[2*k +: 2] = f[16-2*k -: 2];
    end
    f = fetch(t - 3, mode);
    stg_code = cv;
    flash    = f[2:0];
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog R8 actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp    = 0;
    n_bad    = 0;
    rst_n    = 1'b0;
    stg_code = {7{2'b01}};
    flash    = 3'd0;
    #20;
    // R9: reset state
    chk("R9 reset outputs", {22'd0, res, vld, rng, err}, 32'd0);

    @(negedge clk);
    rst_n = 1'b1;
    for (int e = 1; e <= 8; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (e == 7) chk("R8 valid low before fill", {31'd0, vld}, 32'd0);
      if (e == 8) chk("R8 valid after fill", {31'd0, vld}, 32'd1);
    end

    // table stream, samples back to back; result of sample n after edge n+5
    for (int t = 0; t <= NV + 5; t++) begin
      @(negedge clk);
      if (t >= 6)
        chk({vtag(t - 6), " R4 table"}, {20'd0, res, rng, err}, {20'd0, TBL[t-6][11:0]});
      drive_step(t, 0);
    end

    // R4: impulse on idle stream, due exactly six edges after capture
    for (int t = 0; t <= 7; t++) begin
      @(negedge clk);
      if (t == 5) chk("R4 before due", {22'd0, res}, 32'd512);
      if (t == 6) chk("R4 on due",     {22'd0, res}, 32'd768);
      if (t == 7) chk("R4 after due",  {22'd0, res}, 32'd512);
      drive_step(t, 1);
    end
    chk("R8 valid held", {31'd0, vld}, 32'd1);

    // R9: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 async reset", {22'd0, res, vld, rng, err}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule